// File: doc/BRIEF.md
# Dual-Slope Compare Output Generator

This block turns compare-match events from an up/down counting timer into the level on one waveform output pin. Each clock it looks at a match strobe, the direction the counter is moving, whether the programmed compare value sits at the turning point (TOP), a 2-bit output-mode code, the 4-bit waveform-mode setting and a channel select. It then produces a registered waveform level, plus an override enable that tells the pad logic to take the pin away from its ordinary port function.

In the two connected modes the action taken on a match depends on the count direction. This gives centre-aligned pulses whose width follows the compare value. When the compare value equals TOP, the waveform is pinned to a constant level for the whole period. Otherwise a match at the turning point would both set and clear the pin. Output-mode code 01 toggles the pin, but only for the first channel and only in waveform modes 8 through 11. For every other combination that code leaves the pin disconnected.

All results are registered. A change on any input, including a change of output mode, shows on the outputs after the next rising clock edge. The counter, prescaler and pad logic are outside this block.

Top module: `dslope_cmp_out`

## Requirements
- R1: After reset (active-low `rst_n`), `wave_out` is 0 and `pin_override` is 0.
- R2: With `out_mode` = 2'b00, `pin_override` is 0 after the next edge and a match leaves `wave_out` unchanged.
- R3: With `out_mode` = 2'b01, `chan_sel` = 0 (channel A) and `wave_mode` in 8..11, every match inverts `wave_out` at the next edge and `pin_override` is 1.
- R4: With `out_mode` = 2'b01 and either `chan_sel` = 1 (channel B) or `wave_mode` outside 8..11, `pin_override` is 0 and a match leaves `wave_out` unchanged.
- R5: With `out_mode` = 2'b10 and `cmp_at_top` = 0, a match while `count_down` = 0 (counting up) drives `wave_out` to 0, and a match while `count_down` = 1 drives it to 1.
- R6: With `out_mode` = 2'b11 and `cmp_at_top` = 0, a match while counting up drives `wave_out` to 1, and a match while counting down drives it to 0.
- R7: With `out_mode[1]` = 1 and `cmp_at_top` = 1, `wave_out` becomes `out_mode[0]` (0 for 2'b10, 1 for 2'b11) at the next edge, whatever the match strobe and direction are.
- R8: With no match and the R7 case not active, `wave_out` keeps its value.
- R9: With `out_mode[1]` = 1, `pin_override` is 1 after the next edge, in every waveform mode and on both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_match | input | 1 | Compare-match strobe, one cycle per event |
| count_down | input | 1 | 1 while the counter counts down, 0 while it counts up |
| cmp_at_top | input | 1 | 1 when the compare value equals TOP |
| out_mode | input | 2 | Output-mode code |
| wave_mode | input | 4 | Waveform-mode setting of the timer |
| chan_sel | input | 1 | 0 = channel A, 1 = channel B |
| wave_out | output | 1 | Registered waveform level |
| pin_override | output | 1 | Registered enable that overrides the normal port function |

## Verification
Both outputs are due exactly one rising edge after the inputs that cause them. This holds for a match, a direction change, a mode change and the TOP case alike. The bench therefore drives every input on a falling edge, waits for one rising edge and samples at the following falling edge, so each check sees the result of exactly one clocked step. The bench tracks the expected level on its own, so a toggle or a hold is compared against the value it predicted for the previous step.

// File: rtl/dslope_cmp_pkg.sv
package dslope_cmp_pkg;
  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_NONINV = 2'b10,
    OM_INV    = 2'b11
  } out_mode_e;
endpackage

// File: rtl/dslope_mode_decode.sv
module dslope_mode_decode #(
  parameter int WAVE_W    = 4,
  parameter int TOGGLE_LO = 8,
  parameter int TOGGLE_HI = 11
) (
  input  logic [1:0]        out_mode,
  input  logic [WAVE_W-1:0] wave_mode,
  input  logic              chan_sel,
  output logic              toggle_ok,
  output logic              connect
);
  import dslope_cmp_pkg::*;

  localparam logic [WAVE_W-1:0] LO_V = WAVE_W'(TOGGLE_LO);
  localparam logic [WAVE_W-1:0] HI_V = WAVE_W'(TOGGLE_HI);

  logic in_window;
  out_mode_e om;

  always_comb begin
    om        = out_mode_e'(out_mode);
    in_window = (wave_mode >= LO_V) && (wave_mode <= HI_V);
    toggle_ok = (om == OM_TOGGLE) && in_window && !chan_sel;
    unique case (om)
      OM_OFF:    connect = 1'b0;
      OM_TOGGLE: connect = toggle_ok;
      default:   connect = 1'b1;
    endcase
  end
endmodule

// File: rtl/dslope_next_level.sv
module dslope_next_level (
  input  logic       level_q,
  input  logic       cmp_match,
  input  logic       count_down,
  input  logic       cmp_at_top,
  input  logic [1:0] out_mode,
  input  logic       toggle_ok,
  output logic       level_d
);
  import dslope_cmp_pkg::*;

  out_mode_e om;

  always_comb begin
    om      = out_mode_e'(out_mode);
    level_d = level_q;
    if (out_mode[1] && cmp_at_top) begin
      // pinned period: inverting mode sits high, non-inverting low
      level_d = out_mode[0];
    end else if (cmp_match) begin
      unique case (om)
        OM_NONINV: level_d = count_down;
        OM_INV:    level_d = !count_down;
        OM_TOGGLE: level_d = toggle_ok ? !level_q : level_q;
        default:   level_d = level_q;
      endcase
    end
  end
endmodule

// File: rtl/dslope_cmp_out.sv
module dslope_cmp_out #(
  parameter int WAVE_W    = 4,
  parameter int TOGGLE_LO = 8,
  parameter int TOGGLE_HI = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_match,
  input  logic              count_down,
  input  logic              cmp_at_top,
  input  logic [1:0]        out_mode,
  input  logic [WAVE_W-1:0] wave_mode,
  input  logic              chan_sel,
  output logic              wave_out,
  output logic              pin_override
);
  logic toggle_ok, connect, level_d;

  dslope_mode_decode #(
    .WAVE_W(WAVE_W), .TOGGLE_LO(TOGGLE_LO), .TOGGLE_HI(TOGGLE_HI)
  ) u_decode (
    .out_mode (out_mode),
    .wave_mode(wave_mode),
    .chan_sel (chan_sel),
    .toggle_ok(toggle_ok),
    .connect  (connect)
  );

  dslope_next_level u_next (
    .level_q   (wave_out),
    .cmp_match (cmp_match),
    .count_down(count_down),
    .cmp_at_top(cmp_at_top),
    .out_mode  (out_mode),
    .toggle_ok (toggle_ok),
    .level_d   (level_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_out     <= 1'b0;
      pin_override <= 1'b0;
    end else begin
      wave_out     <= level_d;
      pin_override <= connect;
    end
  end

  // R2: disconnected code releases the pin
  assert_off_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b00) |=> !pin_override);

  // R3: toggle on every match in the permitted window
  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b01 && cmp_match && !chan_sel &&
     wave_mode >= WAVE_W'(TOGGLE_LO) && wave_mode <= WAVE_W'(TOGGLE_HI))
    |=> (wave_out != $past(wave_out)));

  // R5: non-inverting direction rule
  assert_noninv_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b10 && cmp_match && !cmp_at_top) |=> (wave_out == $past(count_down)));

  // R6: inverting direction rule
  assert_inv_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b11 && cmp_match && !cmp_at_top) |=> (wave_out != $past(count_down)));

  // R7: compare at TOP pins the level
  assert_top_pinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode[1] && cmp_at_top) |=> (wave_out == $past(out_mode[0])));

  // R8: no event, no change
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_match && !(out_mode[1] && cmp_at_top)) |=> $stable(wave_out));

  // R9: PWM codes always connect the pin
  assert_pwm_connect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode[1] |=> pin_override);
endmodule

// File: tb/test_dslope_cmp_out.sv
module test_dslope_cmp_out;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_match = 1'b0;
  logic       count_down = 1'b0;
  logic       cmp_at_top = 1'b0;
  logic [1:0] out_mode = 2'b00;
  logic [3:0] wave_mode = 4'd0;
  logic       chan_sel = 1'b0;
  logic       wave_out, pin_override;

  int checks = 0;
  int failures = 0;
  logic exp_lvl = 1'b0;

  always #2.5 clk = !clk;

  dslope_cmp_out i_dslope_cmp_out (
    .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match), .count_down(count_down),
    .cmp_at_top(cmp_at_top), .out_mode(out_mode), .wave_mode(wave_mode),
    .chan_sel(chan_sel), .wave_out(wave_out), .pin_override(pin_override)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic m, input logic dn, input logic top,
                      input logic [1:0] om, input logic [3:0] wm, input logic chb);
    cmp_match = m; count_down = dn; cmp_at_top = top;
    out_mode = om; wave_mode = wm; chan_sel = chb;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(1'b1, 1'b1, 1'b0, 2'b11, 4'd9, 1'b0);
    step(1'b1, 1'b1, 1'b0, 2'b11, 4'd9, 1'b0);
    chk("R1", "wave_out", wave_out, 1'b0);
    chk("R1", "pin_override", pin_override, 1'b0);
    rst_n = 1'b1;
    exp_lvl = 1'b0;
  endtask

  task automatic t_noninv;
    step(1'b1, 1'b1, 1'b0, 2'b10, 4'd10, 1'b0); exp_lvl = 1'b1;
    chk("R5", "down match", wave_out, exp_lvl);
    chk("R9", "override noninv", pin_override, 1'b1);
    step(1'b0, 1'b0, 1'b0, 2'b10, 4'd10, 1'b0);
    chk("R8", "hold no match", wave_out, exp_lvl);
    step(1'b1, 1'b0, 1'b0, 2'b10, 4'd1, 1'b1); exp_lvl = 1'b0;
    chk("R5", "up match", wave_out, exp_lvl);
    chk("R9", "override chan B mode 1", pin_override, 1'b1);
  endtask

  task automatic t_inv;
    step(1'b1, 1'b0, 1'b0, 2'b11, 4'd3, 1'b0); exp_lvl = 1'b1;
    chk("R6", "up match", wave_out, exp_lvl);
    step(1'b0, 1'b1, 1'b0, 2'b11, 4'd3, 1'b0);
    chk("R8", "hold direction change", wave_out, exp_lvl);
    step(1'b1, 1'b1, 1'b0, 2'b11, 4'd14, 1'b1); exp_lvl = 1'b0;
    chk("R6", "down match", wave_out, exp_lvl);
    chk("R9", "override inv", pin_override, 1'b1);
  endtask

  task automatic t_toggle;
    step(1'b1, 1'b0, 1'b0, 2'b01, 4'd8, 1'b0); exp_lvl = !exp_lvl;
    chk("R3", "toggle mode 8", wave_out, exp_lvl);
    chk("R3", "override mode 8", pin_override, 1'b1);
    step(1'b1, 1'b1, 1'b0, 2'b01, 4'd11, 1'b0); exp_lvl = !exp_lvl;
    chk("R3", "toggle mode 11", wave_out, exp_lvl);
    step(1'b1, 1'b0, 1'b0, 2'b01, 4'd9, 1'b0); exp_lvl = !exp_lvl;
    chk("R3", "toggle mode 9", wave_out, exp_lvl);
    step(1'b0, 1'b0, 1'b0, 2'b01, 4'd9, 1'b0);
    chk("R8", "toggle idle", wave_out, exp_lvl);
  endtask

  task automatic t_blocked;
    step(1'b1, 1'b0, 1'b0, 2'b01, 4'd12, 1'b0);
    chk("R4", "mode 12 level", wave_out, exp_lvl);
    chk("R4", "mode 12 override", pin_override, 1'b0);
    step(1'b1, 1'b0, 1'b0, 2'b01, 4'd7, 1'b0);
    chk("R4", "mode 7 level", wave_out, exp_lvl);
    chk("R4", "mode 7 override", pin_override, 1'b0);
    step(1'b1, 1'b1, 1'b0, 2'b01, 4'd9, 1'b1);
    chk("R4", "chan B level", wave_out, exp_lvl);
    chk("R4", "chan B override", pin_override, 1'b0);
  endtask

  task automatic t_off;
    step(1'b1, 1'b0, 1'b0, 2'b10, 4'd10, 1'b0); exp_lvl = 1'b0;
    step(1'b1, 1'b1, 1'b0, 2'b10, 4'd10, 1'b0); exp_lvl = 1'b1;
    step(1'b1, 1'b0, 1'b0, 2'b00, 4'd10, 1'b0);
    chk("R2", "level held", wave_out, exp_lvl);
    chk("R2", "override off", pin_override, 1'b0);
    step(1'b1, 1'b1, 1'b1, 2'b00, 4'd9, 1'b0);
    chk("R2", "top ignored", wave_out, exp_lvl);
  endtask

  task automatic t_top;
    step(1'b1, 1'b1, 1'b0, 2'b10, 4'd10, 1'b0); exp_lvl = 1'b1;
    step(1'b1, 1'b1, 1'b1, 2'b10, 4'd10, 1'b0); exp_lvl = 1'b0;
    chk("R7", "noninv down match pinned", wave_out, exp_lvl);
    step(1'b0, 1'b0, 1'b1, 2'b10, 4'd10, 1'b0);
    chk("R7", "noninv idle pinned", wave_out, exp_lvl);
    step(1'b1, 1'b1, 1'b1, 2'b11, 4'd10, 1'b0); exp_lvl = 1'b1;
    chk("R7", "inv down match pinned", wave_out, exp_lvl);
    step(1'b1, 1'b0, 1'b1, 2'b11, 4'd10, 1'b0);
    chk("R7", "inv up match pinned", wave_out, exp_lvl);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_noninv();
    t_inv();
    t_toggle();
    t_blocked();
    t_off();
    t_top();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule